// File: doc/BRIEF.md
# Seconds-counter RTC with alarm

This block is a real-time clock built around a free-running seconds counter (four bytes by default). It is reached over a simple byte-wide register port: an offset address, a write strobe with write data, and a read strobe that returns a byte one clock later. A one-cycle seconds tick from outside advances the counter while counting is enabled. The tick generator, any calendar arithmetic and any power-domain handling are outside this block.

Software loads a new time through a bank of staging bytes. The upper bytes only stage a value. A write to byte 0 loads the whole staged value into the counter in the same clock edge. The usual sequence writes byte 0 as zero, then the upper bytes, then byte 0 with its real value, so that a carry during the update cannot corrupt the upper bytes. The live count is readable byte by byte with no snapshot, so a reader must detect a carry by reading byte 0 again. When the count equals the programmed alarm value while the alarm is enabled, a sticky status bit sets and drives a level interrupt with a clean rising edge. Writing zero to that status bit clears it.

Top module: `secs_rtc`

## Requirements
- R1: After synchronous reset every register and the counter are zero, so counting and the alarm are off, `alarm_irq` is 0 and every offset 0x0 to 0xF reads 0x00.
- R2: The counter adds one on a clock edge where control bit 7 is 1 and `sec_tick` is 1. With bit 7 at 0, or with no tick, the count holds.
- R3: The counter wraps from 0xFFFFFFFF to 0x00000000 on a tick.
- R4: Writes to offsets 0x3, 0x4 and 0x5 stage bytes 1, 2 and 3 and leave the count unchanged. A write of value V to offset 0x2 loads the count with {staged byte 3, byte 2, byte 1, V} on that clock edge, and this load takes priority over a tick in the same cycle.
- R5: A read strobe returns its byte on `bus_rdata` one clock later. The count reads little-endian at offsets 0x6 to 0x9 (byte 0 at 0x6), control reads back at 0x0, the alarm value reads back little-endian at 0xA to 0xD, and offset 0x1 returns the alarm status in bit 0 with the other bits at 0. The staging bytes at 0x2 to 0x5 and the offsets 0xE and 0xF read as 0x00.
- R6: When control bit 1 is 1 and the count equals the alarm value, the alarm status and `alarm_irq` go to 1 on the next clock edge and stay at 1 while the count moves on.
- R7: With control bit 1 at 0, a count equal to the alarm value does not raise `alarm_irq`.
- R8: A write to offset 0x1 with bit 0 at 0 clears the status and drops `alarm_irq` on that clock edge, unless a match is present in the same cycle. A write there with bit 0 at 1 has no effect.
- R9: The read bytes show the live count without latching, so a tick between two byte reads makes the second byte reflect the carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (4) | Register offset from the block's base |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data byte |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data byte, valid one clock after the strobe |
| sec_tick | input | 1 | One-cycle seconds tick |
| alarm_irq | output | 1 | Alarm interrupt, level high while status is set |

## Verification
The assertions check on every cycle that the count holds, steps by one or takes the staged value exactly as the enable, tick and byte-0 write dictate, that a live match with the alarm enabled raises the interrupt on the next edge, that the interrupt never rises without a match and never falls without a clearing write, and that reset leaves the interrupt low. Only the bench's scenarios can show the register map itself: the little-endian byte order, the read latency, the zero readback of the staging bank and spare offsets, the staged-write sequence, the wrap at the top of the count and the torn read across a carry.

// File: rtl/secs_rtc_pkg.sv
package secs_rtc_pkg;

    localparam int BYTE_W      = 8;
    localparam int OFF_CTRL    = 0;
    localparam int OFF_ALMCTL  = 1;
    localparam int OFF_WR_BASE = 2;

    localparam int CTRL_RUN_BIT = 7;
    localparam int CTRL_ALM_BIT = 1;
    localparam int ALM_STS_BIT  = 0;

    typedef enum logic [2:0] {
        R_NONE,
        R_CTRL,
        R_ALMCTL,
        R_STAGE,
        R_LIVE,
        R_ALARM
    } region_e;

    typedef struct packed {
        region_e    kind;
        logic [7:0] idx;
    } dec_t;

    function automatic dec_t decode(input logic [7:0] a, input int nb);
        dec_t d;
        int   ai;
        int   rd_base;
        int   al_base;
        ai      = int'(a);
        rd_base = OFF_WR_BASE + nb;
        al_base = OFF_WR_BASE + 2 * nb;
        d.kind  = R_NONE;
        d.idx   = '0;
        if (ai == OFF_CTRL) begin
            d.kind = R_CTRL;
        end else if (ai == OFF_ALMCTL) begin
            d.kind = R_ALMCTL;
        end else if (ai >= OFF_WR_BASE && ai < rd_base) begin
            d.kind = R_STAGE;
            d.idx  = 8'(ai - OFF_WR_BASE);
        end else if (ai >= rd_base && ai < al_base) begin
            d.kind = R_LIVE;
            d.idx  = 8'(ai - rd_base);
        end else if (ai >= al_base && ai < al_base + nb) begin
            d.kind = R_ALARM;
            d.idx  = 8'(ai - al_base);
        end
        return d;
    endfunction

endpackage

// File: rtl/secs_rtc_regs.sv
module secs_rtc_regs
    import secs_rtc_pkg::*;
#(
    parameter int N_BYTES = 4,
    localparam int CNT_W  = N_BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  dec_t              wdec,
    input  logic              we,
    input  logic [7:0]        wdata,
    output logic [7:0]        ctrl_q,
    output logic [CNT_W-1:0]  alm_val,
    output logic              ld_vld,
    output logic [CNT_W-1:0]  ld_val,
    output logic              clr_req
);

    logic [N_BYTES-1:1][7:0] stg_q;
    logic [N_BYTES-1:0][7:0] alm_q;
    logic [N_BYTES-1:0]      alm_wr;
    logic [N_BYTES-1:0]      stg_wr;

    for (genvar i = 0; i < N_BYTES; i++) begin : g_strobe
        assign alm_wr[i] = we && (wdec.kind == R_ALARM) && (wdec.idx == 8'(i));
        assign stg_wr[i] = we && (wdec.kind == R_STAGE) && (wdec.idx == 8'(i));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            stg_q  <= '0;
            alm_q  <= '0;
        end else begin
            if (we && wdec.kind == R_CTRL) begin
                ctrl_q <= wdata;
            end
            for (int i = 1; i < N_BYTES; i++) begin
                if (stg_wr[i]) stg_q[i] <= wdata;
            end
            for (int i = 0; i < N_BYTES; i++) begin
                if (alm_wr[i]) alm_q[i] <= wdata;
            end
        end
    end

    assign ld_vld  = stg_wr[0];
    assign ld_val  = {stg_q, wdata};
    assign alm_val = alm_q;
    assign clr_req = we && (wdec.kind == R_ALMCTL) && !wdata[ALM_STS_BIT];

endmodule

// File: rtl/secs_rtc_counter.sv
module secs_rtc_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic             ld_vld,
    input  logic [CNT_W-1:0] ld_val,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (ld_vld) begin
            cnt <= ld_val;
        end else if (run && tick) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/secs_rtc_alarm.sv
module secs_rtc_alarm #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alm_en,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] alm_val,
    input  logic             clr_req,
    output logic             status
);

    logic hit;
    assign hit = alm_en && (cnt == alm_val);

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= 1'b0;
        end else if (hit) begin
            status <= 1'b1;
        end else if (clr_req) begin
            status <= 1'b0;
        end
    end

endmodule

// File: rtl/secs_rtc.sv
module secs_rtc
    import secs_rtc_pkg::*;
#(
    parameter int N_BYTES = 4,
    parameter int ADDR_W  = 4,
    localparam int CNT_W  = N_BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_re,
    output logic [7:0]        bus_rdata,
    input  logic              sec_tick,
    output logic              alarm_irq
);

    dec_t             dec;
    logic [7:0]       ctrl_q;
    logic [CNT_W-1:0] alm_val;
    logic             ld_vld;
    logic [CNT_W-1:0] ld_val;
    logic             clr_req;
    logic [CNT_W-1:0] cnt_q;
    logic             sts_q;
    logic             cnt_en;
    logic             alm_en;
    logic [7:0]       rd_mux;

    assign dec    = decode(8'(bus_addr), N_BYTES);
    assign cnt_en = ctrl_q[CTRL_RUN_BIT];
    assign alm_en = ctrl_q[CTRL_ALM_BIT];

    secs_rtc_regs #(.N_BYTES(N_BYTES)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wdec    (dec),
        .we      (bus_we),
        .wdata   (bus_wdata),
        .ctrl_q  (ctrl_q),
        .alm_val (alm_val),
        .ld_vld  (ld_vld),
        .ld_val  (ld_val),
        .clr_req (clr_req)
    );

    secs_rtc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .run    (cnt_en),
        .tick   (sec_tick),
        .ld_vld (ld_vld),
        .ld_val (ld_val),
        .cnt    (cnt_q)
    );

    secs_rtc_alarm #(.CNT_W(CNT_W)) u_alm (
        .clk     (clk),
        .rst     (rst),
        .alm_en  (alm_en),
        .cnt     (cnt_q),
        .alm_val (alm_val),
        .clr_req (clr_req),
        .status  (sts_q)
    );

    always_comb begin
        case (dec.kind)
            R_CTRL:   rd_mux = ctrl_q;
            R_ALMCTL: rd_mux = {7'b0, sts_q};
            R_LIVE:   rd_mux = cnt_q[8*int'(dec.idx) +: 8];
            R_ALARM:  rd_mux = alm_val[8*int'(dec.idx) +: 8];
            default:  rd_mux = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= 8'h00;
        end else if (bus_re) begin
            bus_rdata <= rd_mux;
        end
    end

    assign alarm_irq = sts_q;

endmodule

// File: rtl/secs_rtc_chk.sv
module secs_rtc_chk
    import secs_rtc_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [7:0]        bus_wdata,
    input logic              sec_tick,
    input logic              alarm_irq,
    input logic [7:0]        bus_rdata,
    input logic [CNT_W-1:0]  cnt,
    input logic              ld_vld,
    input logic [CNT_W-1:0]  ld_val,
    input logic              cnt_en,
    input logic              alm_en,
    input logic [CNT_W-1:0]  alm_val
);

    logic clr_wr;
    logic hit;
    assign clr_wr = bus_we && (bus_addr == ADDR_W'(OFF_ALMCTL)) && !bus_wdata[ALM_STS_BIT];
    assign hit    = alm_en && (cnt == alm_val);

    // R1
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!alarm_irq && bus_rdata == 8'h00));

    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (!ld_vld && !(cnt_en && sec_tick)) |=> $stable(cnt));

    // R2 and R3: one step, wrapping at the top
    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        (!ld_vld && cnt_en && sec_tick) |=> (cnt == $past(cnt) + CNT_W'(1)));

    a_r4_load: assert property (@(posedge clk) disable iff (rst)
        ld_vld |=> (cnt == $past(ld_val)));

    a_r6_fire: assert property (@(posedge clk) disable iff (rst)
        hit |=> alarm_irq);

    a_r7_no_spurious: assert property (@(posedge clk) disable iff (rst)
        (!alarm_irq && !hit) |=> !alarm_irq);

    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        (alarm_irq && !clr_wr) |=> alarm_irq);

endmodule

bind secs_rtc secs_rtc_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .sec_tick  (sec_tick),
    .alarm_irq (alarm_irq),
    .bus_rdata (bus_rdata),
    .cnt       (cnt_q),
    .ld_vld    (ld_vld),
    .ld_val    (ld_val),
    .cnt_en    (cnt_en),
    .alm_en    (alm_en),
    .alm_val   (alm_val)
);

// File: tb/secs_rtc_bench.sv
module secs_rtc_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] bus_addr;
    logic       bus_we;
    logic [7:0] bus_wdata;
    logic       bus_re;
    logic [7:0] bus_rdata;
    logic       sec_tick;
    logic       alarm_irq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       re_d;

    always #5 clk = ~clk;

    secs_rtc u_secs_rtc (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_re    (bus_re),
        .bus_rdata (bus_rdata),
        .sec_tick  (sec_tick),
        .alarm_irq (alarm_irq)
    );

    // monitor: a strobe sampled at an edge yields data checked at the next falling edge
    always @(posedge clk) re_d <= bus_re;

    always @(negedge clk) begin
        if (re_d === 1'b1) begin
            logic [7:0] e;
            string      t;
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL scoreboard: read data 0x%02h with no expected item", bus_rdata);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    bad++;
                    $display("FAIL %s: actual 0x%02h expected 0x%02h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic wr_tick(input logic [3:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1; sec_tick = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; sec_tick = 1'b0;
    endtask

    task automatic tick();
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] e, input string t);
        bus_addr = a; bus_re = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic rd_count(input logic [31:0] v, input string t);
        for (int i = 0; i < 4; i++) rd(4'(6 + i), v[8*i +: 8], t);
    endtask

    task automatic chk_irq(input logic e, input string t);
        total++;
        if (alarm_irq !== e) begin
            bad++;
            $display("FAIL %s: alarm_irq actual %0b expected %0b", t, alarm_irq, e);
        end
    endtask

    task automatic stage(input logic [7:0] b1, input logic [7:0] b2, input logic [7:0] b3);
        wr(4'h3, b1); wr(4'h4, b2); wr(4'h5, b3);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
        bus_re = 1'b0; sec_tick = 1'b0;
        idle(3);
        rst = 1'b0;

        // R1: reset state over the whole map
        chk_irq(1'b0, "R1 irq after reset");
        for (int a = 0; a < 16; a++) rd(4'(a), 8'h00, "R1 reset readback");

        // R2: tick ignored while counting is off
        tick();
        rd(4'h6, 8'h00, "R2 tick with run off");
        wr(4'h0, 8'h80);
        rd(4'h0, 8'h80, "R5 control readback");
        tick(); tick(); tick();
        rd(4'h6, 8'h03, "R2 three ticks");
        idle(4);
        rd(4'h6, 8'h03, "R2 hold without tick");

        // R4: staging does not touch the count, byte 0 loads it
        stage(8'h12, 8'h34, 8'h56);
        rd_count(32'h0000_0003, "R4 staging leaves count");
        rd(4'h3, 8'h00, "R5 staging reads zero");
        wr(4'h2, 8'h00);
        rd_count(32'h5634_1200, "R4 zero write loads");
        wr(4'h2, 8'h78);
        rd_count(32'h5634_1278, "R4 final byte0 load");
        wr_tick(4'h2, 8'h9A);
        rd_count(32'h5634_129A, "R4 load beats tick");

        // R9: torn read across a carry
        stage(8'h01, 8'h00, 8'h00);
        wr(4'h2, 8'hFF);
        rd(4'h6, 8'hFF, "R9 first byte0");
        tick();
        rd(4'h7, 8'h02, "R9 byte1 shows carry");
        rd(4'h6, 8'h00, "R9 byte0 reread smaller");

        // R3: wrap at the top of the count
        stage(8'hFF, 8'hFF, 8'hFF);
        wr(4'h2, 8'hFF);
        rd_count(32'hFFFF_FFFF, "R3 before wrap");
        tick();
        rd_count(32'h0000_0000, "R3 after wrap");

        // R6 and R8: alarm fire, sticky, clear
        wr(4'hA, 8'h05);
        rd(4'hA, 8'h05, "R5 alarm byte readback");
        rd(4'hB, 8'h00, "R5 alarm byte1 readback");
        wr(4'h0, 8'h82);
        tick(); tick(); tick(); tick();
        chk_irq(1'b0, "R6 no fire before match");
        tick();
        chk_irq(1'b0, "R6 status one edge after match");
        idle(1);
        chk_irq(1'b1, "R6 fire on match");
        rd(4'h1, 8'h01, "R5 status bit readback");
        tick(); tick();
        chk_irq(1'b1, "R6 sticky after count moves");
        wr(4'h1, 8'h01);
        chk_irq(1'b1, "R8 writing one has no effect");
        wr(4'h1, 8'hFE);
        chk_irq(1'b0, "R8 clear by zero write");
        rd(4'h1, 8'h00, "R8 status reads cleared");

        // R7: match with alarm disabled, then enable
        wr(4'h0, 8'h80);
        stage(8'h00, 8'h00, 8'h00);
        wr(4'h2, 8'h05);
        idle(3);
        chk_irq(1'b0, "R7 no fire while disabled");
        rd(4'hE, 8'h00, "R5 spare offset reads zero");
        rd(4'hF, 8'h00, "R5 spare offset reads zero");
        wr(4'h0, 8'h82);
        idle(1);
        chk_irq(1'b1, "R6 fire after enabling on match");

        idle(2);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule